// File: doc/BRIEF.md
# Masked Byte-Sum Checksum Unit

This block builds a 16-bit running checksum over a stream of memory words presented one per clock. Each word carries a tag that says whether it is a program-memory word or a configuration register. A program word adds every one of its bytes to the sum. A configuration register adds only its least significant byte, and only after that byte is ANDed with a fixed mask picked by the register's index. All additions wrap modulo 2^16.

A caller pulses `start_i` to begin a new sum, presents words with `word_vld_i`, and marks the end of the stream with `end_i`. One clock later the block shows the result on `sum_o` and pulses `done_o`. If `protect_i` is high when the stream ends, the result shown is zero, whatever was summed. Fetching the words from memory is left to the caller.

Top module: `cks_masked_sum`

## Requirements
- R1: After reset, `sum_o` is 0x0000 and `done_o` is low.
- R2: A valid word with `word_is_cfg_i` = 0 adds the unsigned sum of all three bytes of `word_i` (bits 7:0, 15:8 and 23:16) to the accumulator.
- R3: A valid word with `word_is_cfg_i` = 1 adds `word_i[7:0]` ANDed with the mask for `cfg_idx_i`; bits 23:8 have no effect. Masks by index 0 to 6 are 0x03, 0x87, 0xDF, 0xDF, 0xFB, 0xC3, 0xFF.
- R4: A configuration word whose `cfg_idx_i` is 7 adds nothing.
- R5: A word presented with `word_vld_i` low adds nothing.
- R6: `start_i` zeroes the accumulator; a valid word presented in the same cycle as `start_i` is the first term of the new sum.
- R7: At the clock edge that samples `end_i` high, `sum_o` takes the sum including any valid word of that cycle and `done_o` goes high for exactly one cycle; at every other edge `sum_o` holds.
- R8: If `protect_i` is high at the edge that samples `end_i`, `sum_o` becomes 0x0000.
- R9: Sums wrap modulo 2^16: 1408 program words of 0xFFFFFF followed by the seven configuration words 0xFFFFFF at indices 0 to 6 give 0x7485.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Zero the accumulator before this cycle's word |
| word_vld_i | input | 1 | The word on `word_i` is part of the stream |
| word_is_cfg_i | input | 1 | 1: configuration register, 0: program word |
| cfg_idx_i | input | 3 | Configuration register index, selects the mask |
| word_i | input | 24 | Word value |
| end_i | input | 1 | This cycle closes the stream |
| protect_i | input | 1 | Force the closed result to zero |
| sum_o | output | 16 | Latched checksum |
| done_o | output | 1 | One-cycle pulse when `sum_o` is updated |

## Verification
Every result of this block is due exactly one clock edge after the cycle in which `end_i` is presented, since the accumulator and the result register are both updated at that edge with no further stage. The bench drives each cycle's inputs at the falling edge and reads `sum_o` and `done_o` at the next falling edge, half a period after the edge that updated them. It then reads one more cycle to see `done_o` drop and `sum_o` hold, which shows the pulse width and the hold of R7.

// File: rtl/cks_pkg.sv
package cks_pkg;
   // Default masks, index 0 in the least significant byte.
   localparam int unsigned CKS_CFG_N_DEF = 7;
   localparam logic [CKS_CFG_N_DEF*8-1:0] CKS_MASKS_DEF =
      {8'hFF, 8'hC3, 8'hFB, 8'hDF, 8'hDF, 8'h87, 8'h03};

   typedef enum logic {
      WK_CODE = 1'b0,
      WK_CFG  = 1'b1
   } word_kind_e;
endpackage

// File: rtl/cks_term.sv
module cks_term #(
   parameter int unsigned DATA_W = 24,
   parameter int unsigned SUM_W  = 16,
   parameter int unsigned CFG_N  = 7,
   parameter int unsigned IDX_W  = 3,
   parameter logic [CFG_N*8-1:0] CFG_MASKS = cks_pkg::CKS_MASKS_DEF
) (
   input  logic              vld,
   input  logic              is_cfg,
   input  logic [IDX_W-1:0]  idx,
   input  logic [DATA_W-1:0] data,
   output logic [SUM_W-1:0]  addend
);
   import cks_pkg::*;

   localparam int unsigned BYTES = DATA_W / 8;

   if (DATA_W % 8 != 0) begin : g_bad_width
      $error("cks_term: DATA_W must be a whole number of bytes");
   end
   if (SUM_W < 8) begin : g_bad_sum
      $error("cks_term: SUM_W must hold at least one byte");
   end
   if (CFG_N > (1 << IDX_W)) begin : g_bad_idx
      $error("cks_term: IDX_W too narrow for CFG_N");
   end

   // Program word: chained byte adder.
   logic [SUM_W-1:0] part [BYTES+1];
   assign part[0] = '0;
   for (genvar g = 0; g < BYTES; g++) begin : g_byte
      assign part[g+1] = part[g] + SUM_W'(data[g*8 +: 8]);
   end

   // Configuration word: mask lookup; an unknown index leaves the mask zero.
   logic [7:0] mask_sel;
   always_comb begin
      mask_sel = '0;
      for (int k = 0; k < CFG_N; k++) begin
         if (idx == IDX_W'(k)) mask_sel = CFG_MASKS[k*8 +: 8];
      end
   end

   logic [SUM_W-1:0] cfg_term;
   assign cfg_term = SUM_W'(data[7:0] & mask_sel);

   word_kind_e kind;
   assign kind = is_cfg ? WK_CFG : WK_CODE;

   always_comb begin
      if (!vld)                addend = '0;
      else if (kind == WK_CFG) addend = cfg_term;
      else                     addend = part[BYTES];
   end
endmodule

// File: rtl/cks_accum.sv
module cks_accum #(
   parameter int unsigned SUM_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             close,
   input  logic             protect,
   input  logic [SUM_W-1:0] addend,
   output logic [SUM_W-1:0] result,
   output logic             done
);
   logic [SUM_W-1:0] acc, acc_nxt;

   assign acc_nxt = (start ? '0 : acc) + addend;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc    <= '0;
         result <= '0;
         done   <= 1'b0;
      end else begin
         acc  <= acc_nxt;
         done <= close;
         if (close) result <= protect ? '0 : acc_nxt;
      end
   end
endmodule

// File: rtl/cks_masked_sum.sv
module cks_masked_sum #(
   parameter int unsigned DATA_W = 24,
   parameter int unsigned SUM_W  = 16,
   parameter int unsigned CFG_N  = cks_pkg::CKS_CFG_N_DEF,
   parameter int unsigned IDX_W  = 3,
   parameter logic [CFG_N*8-1:0] CFG_MASKS = cks_pkg::CKS_MASKS_DEF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              word_vld_i,
   input  logic              word_is_cfg_i,
   input  logic [IDX_W-1:0]  cfg_idx_i,
   input  logic [DATA_W-1:0] word_i,
   input  logic              end_i,
   input  logic              protect_i,
   output logic [SUM_W-1:0]  sum_o,
   output logic              done_o
);
   logic [SUM_W-1:0] addend;

   cks_term #(
      .DATA_W(DATA_W), .SUM_W(SUM_W), .CFG_N(CFG_N),
      .IDX_W(IDX_W), .CFG_MASKS(CFG_MASKS)
   ) u_term (
      .vld    (word_vld_i),
      .is_cfg (word_is_cfg_i),
      .idx    (cfg_idx_i),
      .data   (word_i),
      .addend (addend)
   );

   cks_accum #(.SUM_W(SUM_W)) u_accum (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start_i),
      .close   (end_i),
      .protect (protect_i),
      .addend  (addend),
      .result  (sum_o),
      .done    (done_o)
   );
endmodule

// File: rtl/cks_masked_sum_chk.sv
module cks_masked_sum_chk #(
   parameter int unsigned DATA_W = 24,
   parameter int unsigned SUM_W  = 16,
   parameter int unsigned CFG_N  = 7,
   parameter int unsigned IDX_W  = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start_i,
   input logic              word_vld_i,
   input logic              word_is_cfg_i,
   input logic [IDX_W-1:0]  cfg_idx_i,
   input logic              end_i,
   input logic              protect_i,
   input logic [SUM_W-1:0]  sum_o,
   input logic              done_o,
   input logic [SUM_W-1:0]  addend
);
   localparam int unsigned MAX_CODE = (DATA_W / 8) * 255;

   assert_code_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
      word_vld_i && !word_is_cfg_i |-> addend <= SUM_W'(MAX_CODE));

   assert_cfg_lowbyte_R3: assert property (@(posedge clk) disable iff (!rst_n)
      word_vld_i && word_is_cfg_i |-> addend <= SUM_W'(255));

   assert_badidx_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
      word_vld_i && word_is_cfg_i && ({1'b0, cfg_idx_i} >= (IDX_W+1)'(CFG_N))
      |-> addend == '0);

   assert_novld_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !word_vld_i |-> addend == '0);

   assert_start_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
      start_i && end_i && !protect_i |=> sum_o == $past(addend));

   assert_done_after_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
      end_i |=> done_o);

   assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !end_i |=> !done_o);

   assert_sum_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !end_i |=> $stable(sum_o));

   assert_protect_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      end_i && protect_i |=> sum_o == '0);
endmodule

bind cks_masked_sum cks_masked_sum_chk #(
   .DATA_W(DATA_W), .SUM_W(SUM_W), .CFG_N(CFG_N), .IDX_W(IDX_W)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .start_i       (start_i),
   .word_vld_i    (word_vld_i),
   .word_is_cfg_i (word_is_cfg_i),
   .cfg_idx_i     (cfg_idx_i),
   .end_i         (end_i),
   .protect_i     (protect_i),
   .sum_o         (sum_o),
   .done_o        (done_o),
   .addend        (addend)
);

// File: tb/tb_cks_masked_sum.sv
`timescale 1ns/1ps
module tb_cks_masked_sum;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0, word_vld_i = 1'b0, word_is_cfg_i = 1'b0;
   logic [2:0]  cfg_idx_i = '0;
   logic [23:0] word_i = '0;
   logic        end_i = 1'b0, protect_i = 1'b0;
   logic [15:0] sum_o;
   logic        done_o;

   int total = 0;
   int bad   = 0;

   always #2.5 clk = ~clk;

   cks_masked_sum dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .word_vld_i(word_vld_i),
      .word_is_cfg_i(word_is_cfg_i), .cfg_idx_i(cfg_idx_i), .word_i(word_i),
      .end_i(end_i), .protect_i(protect_i), .sum_o(sum_o), .done_o(done_o)
   );

   // {is_cfg, idx, word, expected single-word sum}
   localparam int NV = 11;
   localparam logic [43:0] VEC [NV] = '{
      {1'b0, 3'd0, 24'h123456, 16'h009C},  // R2
      {1'b0, 3'd0, 24'hFFFFFF, 16'h02FD},  // R2
      {1'b0, 3'd0, 24'h000000, 16'h0000},  // R2
      {1'b1, 3'd0, 24'hABCDFF, 16'h0003},  // R3
      {1'b1, 3'd1, 24'h00FFFF, 16'h0087},  // R3
      {1'b1, 3'd2, 24'h0012F0, 16'h00D0},  // R3
      {1'b1, 3'd3, 24'h00003C, 16'h001C},  // R3
      {1'b1, 3'd4, 24'hFF00AA, 16'h00AA},  // R3
      {1'b1, 3'd5, 24'h000055, 16'h0041},  // R3
      {1'b1, 3'd6, 24'h0000A5, 16'h00A5},  // R3
      {1'b1, 3'd7, 24'h0000FF, 16'h0000}   // R4
   };

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic cyc(input logic st, input logic vld, input logic cfg,
                      input logic [2:0] idx, input logic [23:0] w,
                      input logic en, input logic pr);
      start_i = st; word_vld_i = vld; word_is_cfg_i = cfg; cfg_idx_i = idx;
      word_i = w; end_i = en; protect_i = pr;
      @(negedge clk);
   endtask

   task automatic idle();
      cyc(1'b0, 1'b0, 1'b0, 3'd0, 24'h0, 1'b0, 1'b0);
   endtask

   initial begin
      #1000000;
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1 sum", sum_o, 16'h0000);
      check("R1 done", {15'b0, done_o}, 16'h0000);
      rst_n = 1'b1;
      @(negedge clk);

      // Table walk: one word per sum, start and end in the same cycle.
      for (int i = 0; i < NV; i++) begin
         cyc(1'b1, 1'b1, VEC[i][43], VEC[i][42:40], VEC[i][39:16], 1'b1, 1'b0);
         check(VEC[i][43] ? "R3/R4 table" : "R2 table", sum_o, VEC[i][15:0]);
      end
      idle();

      // R5/R7: multi-word stream with an invalid gap; end with no word.
      cyc(1'b1, 1'b1, 1'b0, 3'd0, 24'h010203, 1'b0, 1'b0);
      cyc(1'b0, 1'b0, 1'b0, 3'd0, 24'hFFFFFF, 1'b0, 1'b0);
      cyc(1'b0, 1'b1, 1'b1, 3'd1, 24'hFF00FF, 1'b0, 1'b0);
      check("R7 hold before end", {15'b0, done_o}, 16'h0000);
      cyc(1'b0, 1'b0, 1'b0, 3'd0, 24'h0, 1'b1, 1'b0);
      check("R5 gap ignored", sum_o, 16'h008D);
      check("R7 done high", {15'b0, done_o}, 16'h0001);
      cyc(1'b0, 1'b1, 1'b0, 3'd0, 24'h111111, 1'b0, 1'b0);
      check("R7 done one cycle", {15'b0, done_o}, 16'h0000);
      check("R7 sum holds", sum_o, 16'h008D);
      idle();

      // R8: protect forces zero, then an unprotected rerun is nonzero.
      cyc(1'b1, 1'b1, 1'b0, 3'd0, 24'h0A0B0C, 1'b1, 1'b1);
      check("R8 protected", sum_o, 16'h0000);
      cyc(1'b1, 1'b1, 1'b0, 3'd0, 24'h0A0B0C, 1'b1, 1'b0);
      check("R8 unprotected", sum_o, 16'h0021);

      // R9: erased image wraps modulo 2^16.
      cyc(1'b1, 1'b1, 1'b0, 3'd0, 24'hFFFFFF, 1'b0, 1'b0);
      for (int n = 1; n < 1408; n++)
         cyc(1'b0, 1'b1, 1'b0, 3'd0, 24'hFFFFFF, 1'b0, 1'b0);
      for (int k = 0; k < 6; k++)
         cyc(1'b0, 1'b1, 1'b1, 3'(k), 24'hFFFFFF, 1'b0, 1'b0);
      cyc(1'b0, 1'b1, 1'b1, 3'd6, 24'hFFFFFF, 1'b1, 1'b0);
      check("R9 erased image", sum_o, 16'h7485);

      // R6: start clears the wrapped accumulator.
      cyc(1'b1, 1'b1, 1'b0, 3'd0, 24'h000001, 1'b1, 1'b0);
      check("R6 start clears", sum_o, 16'h0001);
      // R6: start without a word, then words, then end.
      cyc(1'b1, 1'b0, 1'b0, 3'd0, 24'hFFFFFF, 1'b0, 1'b0);
      cyc(1'b0, 1'b1, 1'b1, 3'd7, 24'h0000FF, 1'b0, 1'b0);
      cyc(1'b0, 1'b1, 1'b1, 3'd0, 24'h000002, 1'b1, 1'b0);
      check("R6 R4 start then words", sum_o, 16'h0002);
      idle();

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule